// File: doc/BRIEF.md
# Tapped Inverting Delay Line with Pulse Combiners

The block is a synthesizable model of an inverting delay line that has several output taps. Each stage is one register that inverts its input and is advanced by a fast oversampling clock, so a change on the input reaches tap n exactly n clock edges later. The polarity at tap n flips once for each stage it has passed through. The stage count must be odd, so that the far end of the line is an inverted copy of the input.

Three active-low pulse outputs are each formed by a NAND of one signal and the inverse of a later tap. By choosing which taps feed a combiner, the user sets when each pulse starts and how long it lasts. One combiner takes its early input from an external gated clock instead of a tap. The stage count, the list of exposed taps, the taps used by each combiner and a per-stage fanout figure are all parameters. The fanout figure has no effect on the logic. It is only checked for a minimum value when the design is elaborated. The stage count and the tap indices are also checked at elaboration.

Top module: `dly_tap_pulse_gen`

## Requirements
- R1: Each stage inverts its input and advances one `clk` edge; tap n shows the value `din_i` had n edges earlier, inverted when n is odd, so after an input step tap n changes on exactly the n-th edge.
- R2: While `rst` is high at a rising edge of `clk`, every stage is loaded synchronously with 1 if its number is odd and 0 if even, whatever `din_i` is; this is the settled state for a low input.
- R3: `tap_o[i]` carries the stage whose number is held in bits 8i+7..8i of `TAP_LIST`; an entry of 0 selects the last stage.
- R4: With `NUM_TAPS` equal to 0 the tap list is not used and `tap_o` is one bit wide, carrying the last stage.
- R5: `pulse1_n_o` equals NAND(tap `P1_EARLY`, NOT tap `P1_LATE`), defaults 1 and 6, with no register between taps and output.
- R6: `pulse2_n_o` equals NAND(`gclk_i`, NOT tap `P2_LATE`), default 7; with `gclk_i` high it falls on the 7th edge after a rising input step.
- R7: `pulse3_n_o` equals NAND(tap `P3_EARLY`, NOT tap `P3_LATE`), defaults 6 and 14; after a rising input step from the settled low state it is low for exactly 8 cycles, starting after the 6th edge.
- R8: Whenever the late tap of pulse 1 is the early tap of pulse 3, the two pulses are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock that advances every stage |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | 1 | Signal launched into the first stage |
| gclk_i | input | 1 | External gated clock used as the early input of pulse 2 |
| tap_o | output | NUM_TAPS (1 when NUM_TAPS is 0) | Selected stage outputs |
| pulse1_n_o | output | 1 | Active-low pulse from the early tap and inverted late tap of combiner 1 |
| pulse2_n_o | output | 1 | Active-low pulse from the gated clock and inverted late tap of combiner 2 |
| pulse3_n_o | output | 1 | Active-low pulse from the early tap and inverted late tap of combiner 3 |

## Verification
A stage that holds a wrong value shows up on every tap at or after that stage, and on any pulse fed by those taps. Because the line only shifts, the error reaches an exposed tap within as many edges as separate the bad stage from that tap, and it disappears from the line after at most the stage count. A wrong reset value shows on the taps in the first cycle after reset. A wrong delay or polarity moves the start or the width of a pulse by whole cycles. The bench measures these directly after a single input step, and then sweeps a pseudo-random input and gated clock against a model of the line's history.

// File: rtl/dly_pkg.sv
package dly_pkg;

    // width of one entry in a packed tap list
    localparam int unsigned TAP_W = 8;

    // three combiner outputs grouped together
    typedef struct packed {
        logic p1_n;
        logic p2_n;
        logic p3_n;
    } pulse_t;

    // number of tap outputs for a given list length (0 means "no list")
    function automatic int unsigned tap_count(int unsigned num_taps);
        return (num_taps == 0) ? 1 : num_taps;
    endfunction

    // map a list entry onto a stage number; 0 stands for the last stage
    function automatic int unsigned resolve_tap(int unsigned idx, int unsigned num_stages);
        return (idx == 0) ? num_stages : idx;
    endfunction

    // reset level of stage n: settled value for a low input
    function automatic logic stage_rst_level(int unsigned n);
        return (n % 2) == 1;
    endfunction

endpackage

// File: rtl/dly_stage.sv
module dly_stage #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    // one inverting element of the line
    always_ff @(posedge clk) begin
        if (rst) q_o <= RST_VAL;
        else     q_o <= ~d_i;
    end

    AST_STAGE_RESET_LEVEL: assert property (@(posedge clk) rst |=> (q_o == RST_VAL)); // R2

endmodule

// File: rtl/dly_chain.sv
module dly_chain #(
    parameter int unsigned NUM_STAGES = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  din_i,
    output logic [NUM_STAGES:1]   stg_o
);
    import dly_pkg::*;

    for (genvar n = 1; n <= NUM_STAGES; n++) begin : g_stg
        if (n == 1) begin : g_head
            dly_stage #(.RST_VAL(stage_rst_level(n))) u_stage (
                .clk (clk),
                .rst (rst),
                .d_i (din_i),
                .q_o (stg_o[n])
            );
        end else begin : g_body
            dly_stage #(.RST_VAL(stage_rst_level(n))) u_stage (
                .clk (clk),
                .rst (rst),
                .d_i (stg_o[n-1]),
                .q_o (stg_o[n])
            );
            AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (stg_o[n] == ~$past(stg_o[n-1]))); // R1
        end
    end

    AST_HEAD_INVERTS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stg_o[1] == ~$past(din_i))); // R1

endmodule

// File: rtl/dly_tap_sel.sv
module dly_tap_sel #(
    parameter int unsigned NUM_STAGES = 15,
    parameter int unsigned NUM_TAPS   = 5,
    parameter logic [dly_pkg::TAP_W*dly_pkg::tap_count(NUM_TAPS)-1:0] TAP_LIST = '0
) (
    input  logic [NUM_STAGES:1]                        stg_i,
    output logic [dly_pkg::tap_count(NUM_TAPS)-1:0]    tap_o
);
    import dly_pkg::*;

    localparam int unsigned N_OUT = tap_count(NUM_TAPS);

    if (NUM_TAPS == 0) begin : g_default
        // no list: a single output at the far end of the line
        assign tap_o[0] = stg_i[NUM_STAGES];
    end else begin : g_list
        for (genvar i = 0; i < N_OUT; i++) begin : g_tap
            localparam int unsigned SEL = resolve_tap(int'(TAP_LIST[TAP_W*i +: TAP_W]), NUM_STAGES);
            if (SEL < 1 || SEL > NUM_STAGES) begin : g_bad
                $error("tap list entry %0d selects stage %0d outside 1..%0d", i, SEL, NUM_STAGES);
            end else begin : g_ok
                assign tap_o[i] = stg_i[SEL];
            end
        end
    end

endmodule

// File: rtl/dly_pulse.sv
module dly_pulse (
    input  logic early_i,
    input  logic late_i,
    output logic pulse_n_o
);

    // low only while the early signal is high and the late tap is still low
    always_comb pulse_n_o = ~(early_i & ~late_i);

endmodule

// File: rtl/dly_tap_pulse_gen.sv
module dly_tap_pulse_gen #(
    parameter int unsigned NUM_STAGES = 15,
    parameter int unsigned FANOUT     = 2,
    parameter int unsigned NUM_TAPS   = 5,
    parameter logic [dly_pkg::TAP_W*dly_pkg::tap_count(NUM_TAPS)-1:0] TAP_LIST =
        {8'd15, 8'd14, 8'd7, 8'd6, 8'd1},
    parameter int unsigned P1_EARLY   = 1,
    parameter int unsigned P1_LATE    = 6,
    parameter int unsigned P2_LATE    = 7,
    parameter int unsigned P3_EARLY   = 6,
    parameter int unsigned P3_LATE    = 14
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      din_i,
    input  logic                                      gclk_i,
    output logic [dly_pkg::tap_count(NUM_TAPS)-1:0]   tap_o,
    output logic                                      pulse1_n_o,
    output logic                                      pulse2_n_o,
    output logic                                      pulse3_n_o
);
    import dly_pkg::*;

    localparam int unsigned MAX_TAP = NUM_STAGES;

    // ---------------- elaboration-time configuration checks ----------------
    if ((NUM_STAGES % 2) == 0) begin : g_err_even
        $error("stage count %0d is even; the line must invert overall", NUM_STAGES);
    end
    if (FANOUT < 2) begin : g_err_fanout
        $error("per-stage fanout %0d is below 2", FANOUT);
    end
    if (P1_EARLY < 1 || P1_EARLY > MAX_TAP || P1_LATE < 1 || P1_LATE > MAX_TAP ||
        P2_LATE  < 1 || P2_LATE  > MAX_TAP ||
        P3_EARLY < 1 || P3_EARLY > MAX_TAP || P3_LATE < 1 || P3_LATE > MAX_TAP) begin : g_err_ptap
        $error("a combiner tap lies outside 1..%0d", MAX_TAP);
    end

    // ---------------- stage pipeline ----------------
    logic [NUM_STAGES:1] stg;

    dly_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .din_i (din_i),
        .stg_o (stg)
    );

    // ---------------- exposed taps ----------------
    dly_tap_sel #(
        .NUM_STAGES (NUM_STAGES),
        .NUM_TAPS   (NUM_TAPS),
        .TAP_LIST   (TAP_LIST)
    ) u_taps (
        .stg_i (stg),
        .tap_o (tap_o)
    );

    // ---------------- pulse combiners ----------------
    pulse_t pls;

    dly_pulse u_pulse1 (
        .early_i   (stg[P1_EARLY]),
        .late_i    (stg[P1_LATE]),
        .pulse_n_o (pls.p1_n)
    );

    dly_pulse u_pulse2 (
        .early_i   (gclk_i),
        .late_i    (stg[P2_LATE]),
        .pulse_n_o (pls.p2_n)
    );

    dly_pulse u_pulse3 (
        .early_i   (stg[P3_EARLY]),
        .late_i    (stg[P3_LATE]),
        .pulse_n_o (pls.p3_n)
    );

    assign pulse1_n_o = pls.p1_n;
    assign pulse2_n_o = pls.p2_n;
    assign pulse3_n_o = pls.p3_n;

    // pulse 3 needs its early tap high, which blocks pulse 1 when they share that tap
    if (P1_LATE == P3_EARLY) begin : g_excl
        AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            !pulse3_n_o |-> pulse1_n_o); // R8
    end

endmodule

// File: tb/dly_tap_pulse_gen_tb_top.sv
module dly_tap_pulse_gen_tb_top;

    localparam int NS = 15;
    localparam int TL [5] = '{1, 6, 7, 14, 15};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic gclk = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    logic [4:0] tap;
    logic       p1, p2, p3;
    logic [0:0] stap;
    logic       sp1, sp2, sp3;

    dly_tap_pulse_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .din_i      (din),
        .gclk_i     (gclk),
        .tap_o      (tap),
        .pulse1_n_o (p1),
        .pulse2_n_o (p2),
        .pulse3_n_o (p3)
    );

    // short line with no tap list: single output at stage 5
    dly_tap_pulse_gen #(
        .NUM_STAGES (5),
        .NUM_TAPS   (0),
        .TAP_LIST   (8'd0),
        .P1_EARLY   (1),
        .P1_LATE    (2),
        .P2_LATE    (3),
        .P3_EARLY   (2),
        .P3_LATE    (5)
    ) short_i (
        .clk        (clk),
        .rst        (rst),
        .din_i      (din),
        .gclk_i     (gclk),
        .tap_o      (stap),
        .pulse1_n_o (sp1),
        .pulse2_n_o (sp2),
        .pulse3_n_o (sp3)
    );

    // history of the input: hist[k] is din as sampled k+1 edges ago
    logic [NS-1:0] hist;
    always @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[NS-2:0], din};
    end

    function automatic logic exp_tap(int n);
        return hist[n-1] ^ ((n % 2) == 1);
    endfunction

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        for (int i = 0; i < 5; i++)
            chk("R3", $sformatf("tap entry %0d (stage %0d)", i, TL[i]), tap[i], exp_tap(TL[i]));
        chk("R5", "pulse1", p1, ~(exp_tap(1) & ~exp_tap(6)));
        chk("R6", "pulse2", p2, ~(gclk & ~exp_tap(7)));
        chk("R7", "pulse3", p3, ~(exp_tap(6) & ~exp_tap(14)));
        chk("R4", "short line single tap", stap[0], exp_tap(5));
        chk("R5", "short pulse1", sp1, ~(exp_tap(1) & ~exp_tap(2)));
        chk("R8", "pulse1/pulse3 overlap", (!p1 && !p3), 1'b0);
    endtask

    task automatic chk_reset_state(string tag);
        chk("R2", {tag, " taps"}, (tap === 5'b10101), 1'b1);
        chk("R2", {tag, " short tap"}, stap[0], 1'b1);
        chk("R2", {tag, " pulse1"}, p1, 1'b0);
        chk("R2", {tag, " pulse3"}, p3, 1'b1);
    endtask

    initial begin
        int first_p3;
        int width_p3;
        int first_t15;
        int first_p2;
        logic [15:0] lfsr;

        repeat (3) @(negedge clk);
        chk_reset_state("initial");
        rst = 1'b0;

        repeat (3) begin
            @(negedge clk);
            cmp_all();
        end

        // rising step with gated clock held high
        gclk = 1'b1;
        din  = 1'b1;
        first_p3 = -1; width_p3 = 0; first_t15 = -1; first_p2 = -1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            cmp_all();
            if (!p3) begin
                width_p3++;
                if (first_p3 < 0) first_p3 = i;
            end
            if (first_t15 < 0 && tap[4] == 1'b0) first_t15 = i;
            if (first_p2 < 0 && !p2) first_p2 = i;
        end
        checks++; if (first_t15 != 15) begin errors++; $display("FAIL R1 stage15 first change actual=%0d expected=15", first_t15); end
        checks++; if (first_p3 != 6)   begin errors++; $display("FAIL R7 pulse3 start actual=%0d expected=6", first_p3); end
        checks++; if (width_p3 != 8)   begin errors++; $display("FAIL R7 pulse3 width actual=%0d expected=8", width_p3); end
        checks++; if (first_p2 != 7)   begin errors++; $display("FAIL R6 pulse2 start actual=%0d expected=7", first_p2); end

        // settled high: reset must override the input
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_reset_state("reset with input high");
        din = 1'b0;
        rst = 1'b0;

        // falling step from settled high
        din = 1'b1;
        repeat (20) begin @(negedge clk); cmp_all(); end
        din = 1'b0;
        first_t15 = -1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            cmp_all();
            if (first_t15 < 0 && tap[4] == 1'b1) first_t15 = i;
        end
        checks++; if (first_t15 != 15) begin errors++; $display("FAIL R1 stage15 fall delay actual=%0d expected=15", first_t15); end

        // pseudo-random sweep of input and gated clock
        lfsr = 16'hACE1;
        for (int c = 0; c < 600; c++) begin
            din  = lfsr[0];
            gclk = lfsr[5];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            cmp_all();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule